// File: doc/BRIEF.md
# Per-Cycle Bus Wait-State Generator

This block stretches the read or write command of every bus cycle by a number of system-clock periods chosen for that cycle alone. When a cycle starts, the block sorts it into a class. The class depends on whether the cycle is memory or I/O, on its data width, on whether a ROM chip select is active, and, for 8-bit I/O, on which address window the port number falls in. It then takes the wait count from the configuration field that belongs to that class, asserts the command, and holds it until the count has run out.

Four 8-bit configuration registers are written through a simple index/data port. A memory cycle with the ROM chip select active can be flagged to run on the fast CPU clock. That cycle then takes its count from a separate field, and the block raises a clock-select output for as long as the command lasts. The chip-select decoder and the clocks themselves belong to neighbouring logic.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset, rd_cmd, wr_cmd, bus_rdy and fast_clk_sel are low, and every configuration field is zero.
- R2: A cycle with wait count W holds its command for W+1 clock cycles, starting the cycle after cyc_start is sampled. bus_rdy is high only in the last of those cycles, and the command drops at the next edge. is_write=1 drives wr_cmd and is_write=0 drives rd_cmd.
- R3: An 8-bit I/O cycle at 3F0h–3F7h waits 2 + the value of bits 1:0 of register index 61h.
- R4: An 8-bit I/O cycle at 1F0h–1F7h waits 2 + the value of bits 3:2 of index 61h.
- R5: Any other 8-bit I/O cycle at 100h or above, including addresses beyond 3FFh, waits 2 + the value of bits 5:4 of index 61h.
- R6: An 8-bit I/O cycle at 000h–0FFh waits 2 when bit 3 of index 63h is 0, and 4 when it is 1.
- R7: A 16-bit I/O cycle waits 3 when bit 2 of index 63h is 0, and 4 when it is 1, whatever its address window.
- R8: An 8-bit memory cycle that is not a fast ROM cycle waits 2 + the value of bits 1:0 of index 62h.
- R9: A 16-bit memory cycle that is not a fast ROM cycle waits 1 + the value of bits 3:2 of index 62h.
- R10: When bit 6 of index B3h is 1, a memory cycle with rom_cs high waits 1 + the value of bits 5:4 of index B3h, and fast_clk_sel is high for as long as its command lasts. When bit 6 is 0, or on I/O cycles, rom_cs has no effect.
- R11: cyc_start while a command is active starts no cycle and does not change the current length. A configuration write during a command affects only later cycles.
- R12: A write to any index other than 61h, 62h, 63h and B3h changes no wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-cycle strobe that begins a bus cycle |
| is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| is_16 | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| is_write | input | 1 | 1 = write, 0 = read |
| rom_cs | input | 1 | ROM chip select qualifier for the cycle |
| io_addr | input | IO_AW | I/O port address |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| rd_cmd | output | 1 | Stretched read command |
| wr_cmd | output | 1 | Stretched write command |
| bus_rdy | output | 1 | High in the final cycle of the command |
| fast_clk_sel | output | 1 | Cycle runs on the fast CPU clock |

## Verification
The bench probes the window edges: 3EFh, 3F0h, 3F7h and 3F8h, 0FFh against 100h, and an address above 3FFh. A design with an off-by-one window would give those cycles the wrong field's count. It runs 16-bit I/O inside the floppy window, where a design that checked the windows first would use the 8-bit field. It raises rom_cs on I/O cycles and on memory cycles with the fast bit clear, where a leaky fast path would shift the length and raise fast_clk_sel. It also pokes cyc_start and a configuration write in the middle of a command, where a design that reloaded the counter would lengthen the cycle or restart it.

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int          IO_AW    = 16,
  parameter int          CNT_W    = 3,
  parameter logic [7:0]  IDX_IO   = 8'h61,
  parameter logic [7:0]  IDX_MEM  = 8'h62,
  parameter logic [7:0]  IDX_CTL  = 8'h63,
  parameter logic [7:0]  IDX_FAST = 8'hB3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             is_io,
  input  logic             is_16,
  input  logic             is_write,
  input  logic             rom_cs,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_idx,
  input  logic [7:0]       cfg_wdata,
  output logic             rd_cmd,
  output logic             wr_cmd,
  output logic             bus_rdy,
  output logic             fast_clk_sel
);

  localparam logic [31:0] FDD_LO = 32'h3F0;
  localparam logic [31:0] FDD_HI = 32'h3F7;
  localparam logic [31:0] HDD_LO = 32'h1F0;
  localparam logic [31:0] HDD_HI = 32'h1F7;
  localparam logic [31:0] INT_HI = 32'h0FF;

  logic [5:0] io_ws;
  logic [3:0] mem_ws;
  logic [1:0] ctl_ws;
  logic [2:0] fast_ws;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_ws   <= '0;
      mem_ws  <= '0;
      ctl_ws  <= '0;
      fast_ws <= '0;
    end else if (cfg_we) begin
      if (cfg_idx == IDX_IO)   io_ws   <= cfg_wdata[5:0];
      if (cfg_idx == IDX_MEM)  mem_ws  <= cfg_wdata[3:0];
      if (cfg_idx == IDX_CTL)  ctl_ws  <= cfg_wdata[3:2];
      if (cfg_idx == IDX_FAST) fast_ws <= cfg_wdata[6:4];
    end
  end

  logic unused_wdata;
  assign unused_wdata = cfg_wdata[7];

  logic [31:0] a32;
  logic        in_fdd, in_hdd, in_int, fast_hit;
  assign a32      = 32'(io_addr);
  assign in_fdd   = (a32 >= FDD_LO) && (a32 <= FDD_HI);
  assign in_hdd   = (a32 >= HDD_LO) && (a32 <= HDD_HI);
  assign in_int   = (a32 <= INT_HI);
  assign fast_hit = !is_io && rom_cs && fast_ws[2];

  logic [CNT_W-1:0] sel_wait;
  always_comb begin
    if (is_io) begin
      if (is_16)       sel_wait = ctl_ws[0] ? CNT_W'(4) : CNT_W'(3);
      else if (in_fdd) sel_wait = CNT_W'(io_ws[1:0]) + CNT_W'(2);
      else if (in_hdd) sel_wait = CNT_W'(io_ws[3:2]) + CNT_W'(2);
      else if (in_int) sel_wait = ctl_ws[1] ? CNT_W'(4) : CNT_W'(2);
      else             sel_wait = CNT_W'(io_ws[5:4]) + CNT_W'(2);
    end else begin
      if (fast_hit)    sel_wait = CNT_W'(fast_ws[1:0]) + CNT_W'(1);
      else if (is_16)  sel_wait = CNT_W'(mem_ws[3:2]) + CNT_W'(1);
      else             sel_wait = CNT_W'(mem_ws[1:0]) + CNT_W'(2);
    end
  end

  logic             active, wr_lat, fast_lat;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      wr_lat   <= 1'b0;
      fast_lat <= 1'b0;
    end else if (active) begin
      if (cnt == '0) begin
        active   <= 1'b0;
        fast_lat <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end else if (cyc_start) begin
      active   <= 1'b1;
      cnt      <= sel_wait;
      wr_lat   <= is_write;
      fast_lat <= fast_hit;
    end
  end

  assign rd_cmd       = active && !wr_lat;
  assign wr_cmd       = active && wr_lat;
  assign bus_rdy      = active && (cnt == '0);
  assign fast_clk_sel = fast_lat;

  AST_RELEASE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> !rd_cmd && !wr_cmd); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0) |=> active && (cnt == $past(cnt) - CNT_W'(1))); // R2
  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(5))); // R2
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cmd && wr_cmd)); // R2
  AST_FAST_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_sel |-> (rd_cmd || wr_cmd)); // R10
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0 && cyc_start) |=> active && $stable(wr_lat)); // R11

endmodule

// File: tb/tb_bus_wait_gen.sv
`timescale 1ns/1ps
module tb_bus_wait_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 0, is_io = 0, is_16 = 0, is_write = 0, rom_cs = 0;
  logic [15:0] io_addr = '0;
  logic cfg_we = 0;
  logic [7:0] cfg_idx = '0, cfg_wdata = '0;
  logic rd_cmd, wr_cmd, bus_rdy, fast_clk_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_wait_gen dut (.clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .is_io(is_io),
    .is_16(is_16), .is_write(is_write), .rom_cs(rom_cs), .io_addr(io_addr),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .rd_cmd(rd_cmd),
    .wr_cmd(wr_cmd), .bus_rdy(bus_rdy), .fast_clk_sel(fast_clk_sel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Runs one cycle and checks the command length, ready placement and fast select.
  task automatic run(input string req, input bit io, input bit w16, input bit rom,
                     input logic [15:0] a, input bit wr, input int waits,
                     input bit exp_fast, input bit poke);
    int n = 0, r = 0, last = 0, fast_seen = 0, wrong = 0;
    @(negedge clk);
    is_io = io; is_16 = w16; rom_cs = rom; io_addr = a; is_write = wr; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    while ((rd_cmd || wr_cmd) && n < 20) begin
      n++;
      if (bus_rdy) begin r++; last = n; end
      if (fast_clk_sel) fast_seen++;
      if (wr ? (rd_cmd || !wr_cmd) : (wr_cmd || !rd_cmd)) wrong++;
      if (poke && n == 2) begin
        cyc_start = 1; cfg_we = 1; cfg_idx = 8'h61; cfg_wdata = 8'h3F;
      end else begin
        cyc_start = 0; cfg_we = 0;
      end
      @(negedge clk);
    end
    cyc_start = 0; cfg_we = 0;
    chk(n == waits + 1, req, n, waits + 1);
    chk(r == 1 && last == n, {req, " ready placement"}, last, n);
    chk(wrong == 0, {req, " R2 command polarity"}, wrong, 0);
    chk(fast_seen == (exp_fast ? n : 0), {req, " fast select"}, fast_seen, exp_fast ? n : 0);
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(!rd_cmd && !wr_cmd, "R11 no restart", rd_cmd || wr_cmd, 0);
    end
  endtask

  task automatic t_reset();
    chk(!rd_cmd && !wr_cmd && !bus_rdy && !fast_clk_sel, "R1 outputs",
        {rd_cmd, wr_cmd, bus_rdy, fast_clk_sel}, 0);
    run("R1 default floppy", 1, 0, 0, 16'h3F2, 0, 2, 0, 0);
    run("R1 default mem16", 0, 1, 0, 16'h0, 1, 1, 0, 0);
  endtask

  task automatic t_io_windows();
    wr_cfg(8'h61, 8'b00_10_01);                        // other=2, hdd=4, fdd=3
    run("R3 fdd 3F0", 1, 0, 0, 16'h3F0, 0, 3, 0, 0);
    run("R3 fdd 3F7", 1, 0, 0, 16'h3F7, 1, 3, 0, 0);
    run("R5 3F8 other", 1, 0, 0, 16'h3F8, 0, 2, 0, 0);
    run("R5 3EF other", 1, 0, 0, 16'h3EF, 0, 2, 0, 0);
    run("R4 hdd 1F0", 1, 0, 0, 16'h1F0, 0, 4, 0, 0);
    run("R4 hdd 1F7", 1, 0, 0, 16'h1F7, 1, 4, 0, 0);
    run("R5 100 other", 1, 0, 0, 16'h100, 0, 2, 0, 0);
    run("R5 above 3FF", 1, 0, 0, 16'h8000, 0, 2, 0, 0);
    wr_cfg(8'h61, 8'b11_00_11);
    run("R3 fdd max", 1, 0, 0, 16'h3F4, 0, 5, 0, 0);
    run("R5 other max", 1, 0, 0, 16'h2F8, 0, 5, 0, 0);
    run("R6 internal 0FF bit0", 1, 0, 0, 16'h0FF, 0, 2, 0, 0);
    wr_cfg(8'h63, 8'h08);
    run("R6 internal 000 bit1", 1, 0, 0, 16'h000, 0, 4, 0, 0);
    run("R7 io16 bit0", 1, 1, 0, 16'h3F0, 0, 3, 0, 0);
    wr_cfg(8'h63, 8'h04);
    run("R7 io16 bit1", 1, 1, 0, 16'h060, 1, 4, 0, 0);
    run("R6 internal back to 2", 1, 0, 0, 16'h060, 0, 2, 0, 0);
    run("R10 rom_cs on io ignored", 1, 0, 1, 16'h1F3, 0, 2, 0, 0);
  endtask

  task automatic t_memory();
    wr_cfg(8'h62, 8'b10_01);                           // mem16=3, mem8=3
    run("R8 mem8", 0, 0, 0, 16'h0, 0, 3, 0, 0);
    run("R9 mem16", 0, 1, 0, 16'h0, 1, 3, 0, 0);
    wr_cfg(8'h62, 8'b11_11);
    run("R8 mem8 max", 0, 0, 0, 16'h0, 0, 5, 0, 0);
    run("R9 mem16 max", 0, 1, 0, 16'h0, 0, 4, 0, 0);
    wr_cfg(8'hB3, 8'h20);                              // fast off, field 2
    run("R10 fast off rom8", 0, 0, 1, 16'h0, 0, 5, 0, 0);
    wr_cfg(8'hB3, 8'h60);                              // fast on, 3 waits
    run("R10 fast rom8", 0, 0, 1, 16'h0, 0, 3, 1, 0);
    run("R10 fast rom16", 0, 1, 1, 16'h0, 1, 3, 1, 0);
    run("R10 no rom_cs", 0, 0, 0, 16'h0, 0, 5, 0, 0);
    wr_cfg(8'hB3, 8'h40);
    run("R10 fast min", 0, 0, 1, 16'h0, 0, 1, 1, 0);
  endtask

  task automatic t_ignore();
    wr_cfg(8'h61, 8'h00);
    run("R11 poke mid cycle", 1, 0, 0, 16'h3F1, 0, 2, 0, 1);
    run("R11 new cfg later", 1, 0, 0, 16'h3F1, 0, 5, 0, 0);
    wr_cfg(8'h60, 8'hFF);
    wr_cfg(8'h64, 8'h00);
    wr_cfg(8'hE1, 8'h00);
    run("R12 other index fdd", 1, 0, 0, 16'h3F1, 0, 5, 0, 0);
    run("R12 other index mem8", 0, 0, 0, 16'h0, 0, 5, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_io_windows();
    t_memory();
    t_ignore();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule